// File: doc/BRIEF.md
# PLL Coast Window Generator

This block produces the coast signal that tells a line-locked pixel PLL to stop tracking and hold its frequency while the vertical interval passes. During that interval the horizontal sync stream carries equalization pulses and serrations that would disturb the loop. The window must therefore open some lines ahead of vertical sync and close some lines after it. Both margins are programmable in whole line periods.

The block counts horizontal sync leading edges between successive vertical sync leading edges. It keeps that count as the predicted length of the next frame. Once a frame has been measured, the window opens when the running line count reaches the predicted length minus the pre-margin. The window always covers vertical sync itself. After vertical sync ends, the window stays open until the chosen number of further horizontal sync leading edges has been seen.

An externally supplied coast request is merged into the output. Its active level is normally found automatically. An override lets the user dictate that level instead, and a status output reports the level that was found. Horizontal and vertical sync are taken as active-high and synchronous to the pixel clock.

Top module: `coast_window_gen`

## Requirements
- R1: While reset is asserted and after it is released, with no sync activity and the external coast input held low, `coast_out` is 0 and `ext_pol_detected` is 1.
- R2: From the cycle after a vertical sync leading edge until vertical sync falls, `coast_out` is 1.
- R3: Let P be the latched frame length and p be `pre_lines`, with 1 ≤ p < P and the window closed. When the line count (horizontal sync leading edges since the last vertical sync leading edge) becomes P − p, the window opens on the next cycle. It then stays open through the following vertical sync.
- R4: After vertical sync falls, the window stays open until the q-th later horizontal sync leading edge, where q is `post_lines`. With q = 0 it closes the cycle after vertical sync falls.
- R5: If `pre_lines` is 0, or exceeds the latched frame length, or fewer than two vertical sync leading edges have been seen since reset, no window opens before vertical sync.
- R6: At every vertical sync leading edge except the first after reset, the frame length is relatched to the line count of the frame just ended. The prediction therefore follows frames whose length changes.
- R7: Without override, the detector treats the external input as active-high (status 1) while it has mostly been low. After the input has been high for 2^(DET_W−1) more cycles than low (128 by default), the detector treats it as active-low (status 0).
- R8: With `ext_pol_override` set, `ext_pol_user` picks the active level of the external input (1 = active-high, 0 = active-low), whatever the detector reports.
- R9: `coast_out` is the OR of the generated window and the external input taken at its active level. The external path has no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, active-high |
| vsync_in | input | 1 | Vertical sync, active-high |
| pre_lines | input | 8 | Lines of coast ahead of vertical sync |
| post_lines | input | 8 | Lines of coast after vertical sync |
| ext_coast_in | input | 1 | External coast request, either polarity |
| ext_pol_override | input | 1 | 1 = use `ext_pol_user` as the external polarity |
| ext_pol_user | input | 1 | User polarity for the external input, 1 = active-high |
| coast_out | output | 1 | Active-high coast to the PLL |
| ext_pol_detected | output | 1 | Detected external polarity, 1 = positive |

## Verification
The window is tested with several kinds of frame sequence:
- Frames of fixed and of varying length. Varying lengths separate a prediction built on the previous frame from one built on the current frame or on a stale value.
- Pre-margins of zero, small values, and values beyond the frame length. These separate early opening from opening at vertical sync.
- Post-margins from zero to several lines, with vertical sync widths of one to four lines. These locate the exact closing line.
- The first frames after each reset. These show that no prediction is made before a full frame has been measured.

The external path is tested in two ways. Held levels followed by short opposite pulses separate the detected active-low case from the active-high case. Override settings show that the user bit takes precedence over the detector.

// File: rtl/coast_pkg.sv
// Shared types for the coast window generator.
package coast_pkg;

    // Window sequencer states: closed, opened early, covering vsync, trailing
    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_PRE  = 2'd1,
        WIN_SYNC = 2'd2,
        WIN_POST = 2'd3
    } win_state_t;

endpackage

// File: rtl/coast_line_tracker.sv
// Detects sync leading/trailing edges, counts lines since the last vsync
// leading edge and latches the length of each completed frame.
// Assumes: hsync/vsync active-high, synchronous to clk. A hsync edge that
// coincides with a vsync leading edge is not counted.
module coast_line_tracker #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_in,
    input  logic              vsync_in,
    output logic              hs_rise,
    output logic              vs_rise,
    output logic              vs_fall,
    output logic [LINE_W-1:0] line_cnt,
    output logic [LINE_W-1:0] frame_len,
    output logic              meas_valid
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic hs_q, vs_q, seen_vs;

    // Previous-cycle sync levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hsync_in;
            vs_q <= vsync_in;
        end
    end

    assign hs_rise = hsync_in & ~hs_q;
    assign vs_rise = vsync_in & ~vs_q;
    assign vs_fall = ~vsync_in & vs_q;

    // Saturating line counter, cleared by each vsync leading edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_cnt <= '0;
        else if (vs_rise)
            line_cnt <= '0;
        else if (hs_rise && line_cnt != LINE_MAX)
            line_cnt <= line_cnt + 1'b1;
    end

    // Frame length latch; valid only once a whole frame lies between two edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_vs    <= 1'b0;
            frame_len  <= '0;
            meas_valid <= 1'b0;
        end else if (vs_rise) begin
            seen_vs <= 1'b1;
            if (seen_vs) begin
                frame_len  <= line_cnt;
                meas_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/coast_window_fsm.sv
// Sequences the coast window: early opening from the predicted frame length,
// coverage of vsync, and a trailing margin counted in hsync leading edges.
// Assumes: edge strobes are single-cycle pulses from coast_line_tracker.
module coast_window_fsm
    import coast_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_rise,
    input  logic              vs_rise,
    input  logic              vs_fall,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [LINE_W-1:0] frame_len,
    input  logic              meas_valid,
    input  logic [CNT_W-1:0]  pre_lines,
    input  logic [CNT_W-1:0]  post_lines,
    output logic              window
);
    localparam int SUM_W = ((LINE_W > CNT_W) ? LINE_W : CNT_W) + 1;

    win_state_t       state;
    logic [CNT_W-1:0] post_cnt;
    logic [CNT_W:0]   post_next;
    logic [SUM_W-1:0] sum_lines, len_ext;
    logic             pre_hit;

    // Line count plus margin equals predicted length: time to open early
    assign sum_lines = SUM_W'(line_cnt) + SUM_W'(pre_lines);
    assign len_ext   = SUM_W'(frame_len);
    assign pre_hit   = meas_valid && (pre_lines != '0) && (sum_lines == len_ext);
    assign post_next = {1'b0, post_cnt} + {{CNT_W{1'b0}}, 1'b1};

    // Window state transitions and trailing-line counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= WIN_IDLE;
            post_cnt <= '0;
        end else begin
            unique case (state)
                WIN_IDLE: begin
                    if (vs_rise)      state <= WIN_SYNC;
                    else if (pre_hit) state <= WIN_PRE;
                end
                WIN_PRE: begin
                    if (vs_rise) state <= WIN_SYNC;
                end
                WIN_SYNC: begin
                    if (vs_fall) begin
                        post_cnt <= '0;
                        state    <= (post_lines == '0) ? WIN_IDLE : WIN_POST;
                    end
                end
                WIN_POST: begin
                    if (vs_rise) begin
                        state <= WIN_SYNC;
                    end else if (hs_rise) begin
                        if (post_next >= {1'b0, post_lines}) state <= WIN_IDLE;
                        else post_cnt <= post_next[CNT_W-1:0];
                    end
                end
                default: state <= WIN_IDLE;
            endcase
        end
    end

    assign window = (state != WIN_IDLE);
endmodule

// File: rtl/coast_ext_polarity.sv
// Normalizes the external coast request to active-high. The active level is
// found by a saturating up/down counter (up when high, down when low): a
// counter in its lower half means the input idles low, i.e. active-high.
// Assumes: the external input spends most of its time inactive.
module coast_ext_polarity #(
    parameter int DET_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_coast_in,
    input  logic override,
    input  logic user_pol,
    output logic ext_active,
    output logic pol_detected
);
    localparam logic [DET_W-1:0] DET_MAX = '1;

    logic [DET_W-1:0] level_cnt;
    logic             pol_used;

    // Saturating level balance of the external input
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_cnt <= '0;
        else if (ext_coast_in && level_cnt != DET_MAX)
            level_cnt <= level_cnt + 1'b1;
        else if (!ext_coast_in && level_cnt != '0)
            level_cnt <= level_cnt - 1'b1;
    end

    assign pol_detected = ~level_cnt[DET_W-1];
    assign pol_used     = override ? user_pol : pol_detected;
    assign ext_active   = pol_used ? ext_coast_in : ~ext_coast_in;
endmodule

// File: rtl/coast_window_gen.sv
// Top of the coast window generator: line tracking, window sequencing and
// external request merge. Output coast is active-high.
// Assumes: LINE_W >= bits needed for the longest frame in lines.
module coast_window_gen #(
    parameter int LINE_W = 11,
    parameter int CNT_W  = 8,
    parameter int DET_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic [CNT_W-1:0] pre_lines,
    input  logic [CNT_W-1:0] post_lines,
    input  logic             ext_coast_in,
    input  logic             ext_pol_override,
    input  logic             ext_pol_user,
    output logic             coast_out,
    output logic             ext_pol_detected
);
    logic              hs_rise, vs_rise, vs_fall, meas_valid, window, ext_active;
    logic [LINE_W-1:0] line_cnt, frame_len;

    coast_line_tracker #(.LINE_W(LINE_W)) u_track (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hs_rise(hs_rise), .vs_rise(vs_rise), .vs_fall(vs_fall),
        .line_cnt(line_cnt), .frame_len(frame_len), .meas_valid(meas_valid)
    );

    coast_window_fsm #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .vs_rise(vs_rise),
        .vs_fall(vs_fall), .line_cnt(line_cnt), .frame_len(frame_len),
        .meas_valid(meas_valid), .pre_lines(pre_lines),
        .post_lines(post_lines), .window(window)
    );

    coast_ext_polarity #(.DET_W(DET_W)) u_ext (
        .clk(clk), .rst_n(rst_n), .ext_coast_in(ext_coast_in),
        .override(ext_pol_override), .user_pol(ext_pol_user),
        .ext_active(ext_active), .pol_detected(ext_pol_detected)
    );

    // Final coast: generated window or normalized external request
    assign coast_out = window | ext_active;
endmodule

// File: rtl/coast_window_checker.sv
// Temporal checks on the coast window generator, bound into its top.
module coast_window_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vsync_in,
    input logic             ext_coast_in,
    input logic             ext_pol_override,
    input logic             ext_pol_user,
    input logic             coast_out,
    input logic             window,
    input logic             meas_valid,
    input logic             hs_rise,
    input logic             vs_rise,
    input logic             vs_fall,
    input logic [CNT_W-1:0] pre_lines
);
    // R2: held vsync is always covered
    assert_sync_cover_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vsync_in) && vsync_in) |-> coast_out);

    // R8: override with input at the user's active level forces coast
    assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_pol_override && (ext_coast_in == ext_pol_user)) |-> coast_out);

    // R4: window closes only on a hsync edge or a vsync trailing edge
    assert_post_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(window) |-> ($past(hs_rise) || $past(vs_fall)));

    // R3: window opens only on vsync or an enabled prediction
    assert_pre_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window) |-> ($past(vs_rise) ||
                           ($past(meas_valid) && $past(pre_lines) != '0)));

    // R6: once measured, the frame length stays valid until reset
    assert_meas_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(meas_valid) |-> meas_valid);
endmodule

bind coast_window_gen coast_window_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in),
    .ext_coast_in(ext_coast_in), .ext_pol_override(ext_pol_override),
    .ext_pol_user(ext_pol_user), .coast_out(coast_out), .window(window),
    .meas_valid(meas_valid), .hs_rise(hs_rise), .vs_rise(vs_rise),
    .vs_fall(vs_fall), .pre_lines(pre_lines)
);

// File: tb/test_coast_window_gen.sv
`timescale 1ns/1ps
module test_coast_window_gen;
    localparam int LINE_P = 20;   // clocks per line
    localparam int NFR    = 4;    // frames per episode

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0, vsync_in = 1'b0;
    logic [7:0] pre_lines = '0, post_lines = '0;
    logic       ext_coast_in = 1'b0, ext_pol_override = 1'b0, ext_pol_user = 1'b0;
    logic       coast_out, ext_pol_detected;

    int checks = 0, fails = 0;
    bit done = 0;
    int ep_p, ep_q, ep_v;
    int lens [0:NFR+1];

    always #2.5 clk = ~clk;

    coast_window_gen i_coast_window_gen (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .pre_lines(pre_lines), .post_lines(post_lines),
        .ext_coast_in(ext_coast_in), .ext_pol_override(ext_pol_override),
        .ext_pol_user(ext_pol_user), .coast_out(coast_out),
        .ext_pol_detected(ext_pol_detected)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; hsync_in = 1'b0; vsync_in = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(3);
    endtask

    // Expected coast at mid-line (offset 6) of line j in frame f
    function automatic bit exp_coast(int f, int j);
        int c, pl;
        bit ok, vs_hi, post_hi, pre_hi;
        if (j == 0) begin
            ok = (f >= 3); c = (f >= 2) ? lens[f-1] : 0; pl = ok ? lens[f-2] : 0;
        end else begin
            ok = (f >= 2); c = j; pl = ok ? lens[f-1] : 0;
        end
        vs_hi   = (j >= 1) && (j <= ep_v);
        post_hi = (j >= ep_v + 1) && (j <= ep_v + ep_q - 1);
        pre_hi  = ok && (ep_p >= 1) && (ep_p < pl) && (c >= pl - ep_p);
        return vs_hi | post_hi | pre_hi;
    endfunction

    function automatic string tag_of(int f, int j);
        if (j >= 1 && j <= ep_v) return "R2";
        if (j > ep_v && j < ep_v + ep_q) return "R4";
        if (ep_p >= 1 && ep_p < 24) return "R3 R6";
        return "R5";
    endfunction

    task automatic run_line(int f, int j);
        for (int o = 0; o < LINE_P; o++) begin
            @(negedge clk);
            hsync_in = (o < 2);
            if (o == 12 && j == 0) vsync_in = 1'b1;
            if (o == 12 && j == ep_v && j != 0) vsync_in = 1'b0;
            if (o == 6) begin
                #1 chk(tag_of(f, j), coast_out, exp_coast(f, j));
            end
        end
    endtask

    task automatic run_episode();
        pre_lines = 8'(ep_p); post_lines = 8'(ep_q);
        ext_pol_override = 1'b1; ext_pol_user = 1'b1; ext_coast_in = 1'b0;
        do_reset();
        for (int f = 1; f <= NFR; f++)
            for (int j = 0; j < lens[f]; j++) run_line(f, j);
        run_line(NFR + 1, 0);
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        cycles(2);
        #1 chk("R1", coast_out, 1'b0);
        chk("R1", ext_pol_detected, 1'b1);
        do_reset();
        #1 chk("R1", coast_out, 1'b0);
        chk("R1", ext_pol_detected, 1'b1);

        // R7/R9: input idling high becomes active-low
        ext_coast_in = 1'b1;
        cycles(10);
        #1 chk("R9", coast_out, 1'b1);          // still treated active-high
        cycles(300);
        #1 chk("R7", ext_pol_detected, 1'b0);
        chk("R9", coast_out, 1'b0);
        @(negedge clk); ext_coast_in = 1'b0;
        cycles(3);
        #1 chk("R9", coast_out, 1'b1);          // low pulse is a request
        chk("R7", ext_pol_detected, 1'b0);
        // back to idling low: becomes active-high
        cycles(400);
        #1 chk("R7", ext_pol_detected, 1'b1);
        chk("R9", coast_out, 1'b0);
        @(negedge clk); ext_coast_in = 1'b1;
        #1 chk("R9", coast_out, 1'b1);
        @(negedge clk); ext_coast_in = 1'b0;

        // R8: override picks the active level
        ext_pol_override = 1'b1; ext_pol_user = 1'b0;
        #1 chk("R8", coast_out, 1'b1);
        ext_pol_user = 1'b1;
        #1 chk("R8", coast_out, 1'b0);
        ext_coast_in = 1'b1;
        #1 chk("R8", coast_out, 1'b1);

        // Directed: no margins (R2, R4, R5)
        ep_p = 0; ep_q = 0; ep_v = 2;
        for (int f = 1; f <= NFR; f++) lens[f] = 30;
        run_episode();
        // Directed: pre beyond frame length (R5)
        ep_p = 200; ep_q = 3; ep_v = 1;
        run_episode();
        // Directed: shrinking frames (R3, R6)
        ep_p = 10; ep_q = 2; ep_v = 3;
        lens[1] = 30; lens[2] = 30; lens[3] = 20; lens[4] = 36;
        run_episode();
        // Directed: one-line post and four-line vsync (R4)
        ep_p = 5; ep_q = 1; ep_v = 4;
        for (int f = 1; f <= NFR; f++) lens[f] = 26;
        run_episode();

        // Constrained random episodes
        for (int e = 0; e < 10; e++) begin
            ep_v = 1 + int'($urandom % 4);
            ep_q = int'($urandom % 6);
            if ($urandom % 4 == 0) ep_p = 41 + int'($urandom % 215);
            else ep_p = int'($urandom % (24 - ep_v - ep_q));
            for (int f = 1; f <= NFR; f++) lens[f] = 24 + int'($urandom % 17);
            run_episode();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule